// File: doc/BRIEF.md
# Indirect Index/Data Register Window for an Interrupt Redirection Table

This block is a memory-mapped slave that reaches a small internal register space through two bus-visible locations: a select register that names an internal register and a 32-bit data window that reads or writes whatever the select register names. The internal space holds an identification value, a read-only version word, an arbitration word that mirrors the identification value, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves, one per select value.

Software first writes a selector to the select location, then reads or writes the data window. Only the low address byte is decoded, so the block may sit in a wider address aperture. The table lives in the block and every entry is exposed on a flat output bus. A successful table write is followed by a one-cycle service strobe that tells the downstream delivery logic to rescan the table. Delivery logic itself is outside this block.

The control flow is a three-state machine. `ST_IDLE` is entered after reset and after any cycle that neither returned read data nor wrote the table. `ST_RD_DONE` is entered after a cycle that accepted a read; in it `bus_rvalid` is high. `ST_WR_SVC` is entered after a cycle that wrote a table half; in it `svc_strobe` is high. Every state can reach every other state: a read request leads to `ST_RD_DONE`, a table write to `ST_WR_SVC`, and anything else, including no request, to `ST_IDLE`.

Top module: `redir_window`

## Requirements
- R1: After reset the selector is 0x00, the stored ID is 0, `bus_rvalid` and `svc_strobe` are low, and every table entry holds 0x0000_0000_0001_0000.
- R2: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the select register and offset 0x10 is the data window, and the upper address bits are ignored. Any other offset reads 0, and a write to it has no effect.
- R3: A write to offset 0x00 loads `bus_wdata[7:0]` into the selector, whatever the access size. A read of offset 0x00 returns the selector zero-extended to 32 bits.
- R4: `bus_rvalid` is high for exactly the cycle after a cycle with a read request. `bus_rdata` carries the read value in that cycle and holds it until the next read.
- R5: A window access whose `bus_size` is not 4 is ignored. A read returns 0, and a write changes no state and raises no strobe.
- R6: Selectors 0x00 and 0x02 both read the stored 4-bit ID in bits [27:24], with all other bits 0. A window write with selector 0x00 loads the ID from `bus_wdata[27:24]`.
- R7: Selector 0x01 reads 0x11 in bits [7:0] and (NUM_PINS-1) in bits [23:16], with all other bits 0. Window writes with selector 0x01 or 0x02 are ignored.
- R8: For selectors from 0x10 upward the entry index is (selector-0x10)>>1. An odd selector reaches bits [63:32] and an even selector reaches bits [31:0]. Entry i appears on `entries_o[64*i+63:64*i]`.
- R9: A window write to one half of an entry replaces only that half and keeps the other half.
- R10: `svc_strobe` is high for exactly one cycle, the cycle after a size-4 window write that reaches a table entry. No other write raises it.
- R11: Selectors 0x03 to 0x0F, and selectors whose index is NUM_PINS or above, read 0. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| entries_o | output | 64*NUM_PINS | All redirection entries, entry i at bits [64*i+63:64*i] |
| svc_strobe | output | 1 | One-cycle pulse after a table write |

## Verification
The bench targets the places where an index/data window usually goes wrong.

An odd/even half mix-up would land data in the wrong half or clobber the half that should be kept. The bench catches this by writing both halves of the same entry and then rewriting one half.

An off-by-one in the range check would let selector 0x10+2*NUM_PINS alias entry 0, or would let selectors 0x03 to 0x0F reach the table. The bench reads and writes both regions.

Size filtering that is missing on reads or on writes would show up as a nonzero byte-read, or as an entry that changes and a strobe that fires after a 2-byte write. The bench also checks that aliased upper address bits, the ignored version and arbitration writes, and the one-cycle strobe and response widths are handled correctly.

// File: rtl/redir_pkg.sv
package redir_pkg;
    localparam logic [7:0] OFS_SEL      = 8'h00;
    localparam logic [7:0] OFS_WIN      = 8'h10;
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TAB_BASE = 8'h10;
    localparam logic [7:0] VER_CONST    = 8'h11;
    localparam int         ID_LSB       = 24;
    localparam int         ID_W         = 4;
    localparam int         MAXENT_LSB   = 16;
    localparam logic [63:0] ENTRY_RST   = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_VER,
        K_ARB,
        K_ENTRY
    } win_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_DONE,
        ST_WR_SVC
    } win_state_e;
endpackage

// File: rtl/redir_decode.sv
module redir_decode
    import redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic [7:0]       ofs,
    input  logic [7:0]       sel,
    input  logic [3:0]       size,
    output logic             is_sel,
    output logic             is_win,
    output logic             size_ok,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    logic [8:0] diff;
    logic [7:0] full_idx;
    logic       in_range;
    logic       unused_diff_lsb;

    always_comb begin
        is_sel   = (ofs == OFS_SEL);
        is_win   = (ofs == OFS_WIN);
        size_ok  = (size == 4'd4);
        diff     = {1'b0, sel} - {1'b0, SEL_TAB_BASE};
        full_idx = {1'b0, diff[7:1]};
        in_range = !diff[8] && (full_idx < 8'(NUM_PINS));
        idx      = full_idx[IDX_W-1:0];
        hi       = sel[0];
        unique case (sel)
            SEL_ID:  kind = K_ID;
            SEL_VER: kind = K_VER;
            SEL_ARB: kind = K_ARB;
            default: kind = in_range ? K_ENTRY : K_NONE;
        endcase
    end

    assign unused_diff_lsb = diff[0];
endmodule

// File: rtl/redir_table.sv
module redir_table
    import redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     hi,
    input  logic [31:0]              wr_data,
    output logic [31:0]              rd_word,
    output logic [NUM_PINS*64-1:0]   entries_o
);
    logic [63:0] ent_q [NUM_PINS];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= ENTRY_RST;
            end else if (wr_en && (idx == IDX_W'(i))) begin
                if (hi) ent_q[i][63:32] <= wr_data;
                else    ent_q[i][31:0]  <= wr_data;
            end
        end
        assign entries_o[64*i +: 64] = ent_q[i];

        AST_LO_KEPT_ON_HI_WR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hi && idx == IDX_W'(i)) |=> (ent_q[i][31:0] == $past(ent_q[i][31:0]))); // R9
        AST_HI_KEPT_ON_LO_WR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !hi && idx == IDX_W'(i)) |=> (ent_q[i][63:32] == $past(ent_q[i][63:32]))); // R9
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (idx == IDX_W'(i)) rd_word = hi ? ent_q[i][63:32] : ent_q[i][31:0];
        end
    end
endmodule

// File: rtl/redir_fsm.sv
module redir_fsm
    import redir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_go,
    input  logic tab_wr_go,
    output logic rvalid,
    output logic svc_strobe
);
    win_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (rd_go)          state_d = ST_RD_DONE;
        else if (tab_wr_go) state_d = ST_WR_SVC;
        else                state_d = ST_IDLE;
    end

    always_comb begin
        rvalid     = 1'b0;
        svc_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_DONE: rvalid     = 1'b1;
            ST_WR_SVC:  svc_strobe = 1'b1;
            default:    ;
        endcase
    end

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid && svc_strobe)); // R4
endmodule

// File: rtl/redir_window.sv
module redir_window
    import redir_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [3:0]             bus_size,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    output logic [NUM_PINS*64-1:0] entries_o,
    output logic                   svc_strobe
);
    localparam int IDX_W = $clog2(NUM_PINS);
    localparam logic [31:0] VER_WORD =
        32'(VER_CONST) | (32'(NUM_PINS - 1) << MAXENT_LSB);

    logic [7:0]      sel_q;
    logic [ID_W-1:0] id_q;
    logic [31:0]     rdata_q;
    logic            is_sel, is_win, size_ok, hi;
    win_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic [31:0]     tab_word, rd_val;
    logic            wr_any, rd_go, sel_wr, id_wr, tab_wr, win_ok;
    logic            unused_addr_hi;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

    redir_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
        .ofs(bus_addr[7:0]), .sel(sel_q), .size(bus_size),
        .is_sel(is_sel), .is_win(is_win), .size_ok(size_ok),
        .kind(kind), .idx(idx), .hi(hi)
    );

    assign wr_any = bus_req && bus_we;
    assign rd_go  = bus_req && !bus_we;
    assign win_ok = is_win && size_ok;
    assign sel_wr = wr_any && is_sel;
    assign id_wr  = wr_any && win_ok && (kind == K_ID);
    assign tab_wr = wr_any && win_ok && (kind == K_ENTRY);

    redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(tab_wr), .idx(idx), .hi(hi),
        .wr_data(bus_wdata), .rd_word(tab_word), .entries_o(entries_o)
    );

    redir_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .tab_wr_go(tab_wr),
        .rvalid(bus_rvalid), .svc_strobe(svc_strobe)
    );

    always_comb begin
        rd_val = '0;
        if (is_sel) begin
            rd_val = {24'b0, sel_q};
        end else if (win_ok) begin
            unique case (kind)
                K_ID, K_ARB: rd_val = 32'(id_q) << ID_LSB;
                K_VER:       rd_val = VER_WORD;
                K_ENTRY:     rd_val = tab_word;
                default:     rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            id_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (sel_wr) sel_q   <= bus_wdata[7:0];
            if (id_wr)  id_q    <= bus_wdata[ID_LSB +: ID_W];
            if (rd_go)  rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> bus_rvalid); // R4
    AST_NO_RVALID_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> !bus_rvalid); // R4
    AST_STROBE_AFTER_TAB_WR: assert property (@(posedge clk) disable iff (!rst_n)
        tab_wr |=> svc_strobe); // R10
    AST_NO_STROBE_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && is_win && !size_ok) |=> !svc_strobe); // R5
    AST_BAD_SIZE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && is_win && !size_ok) |=> (bus_rdata == 32'd0)); // R5
    AST_SEL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(bus_wdata[7:0]))); // R3
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(bus_rdata)); // R4
endmodule

// File: tb/test_redir_window.sv
`timescale 1ns/1ps
module test_redir_window;
    localparam int ADDR_W   = 12;
    localparam int NUM_PINS = 24;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   bus_req = 1'b0;
    logic                   bus_we = 1'b0;
    logic [ADDR_W-1:0]      bus_addr = '0;
    logic [3:0]             bus_size = 4'd4;
    logic [31:0]            bus_wdata = '0;
    logic [31:0]            bus_rdata;
    logic                   bus_rvalid;
    logic [NUM_PINS*64-1:0] entries_o;
    logic                   svc_strobe;

    int checks = 0;
    int failures = 0;

    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [63:0] m_tab [NUM_PINS];

    always #2 clk = ~clk;

    redir_window #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) i_redir_window (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .entries_o(entries_o), .svc_strobe(svc_strobe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int tab_index(input logic [7:0] s);
        if (s < 8'h10) return -1;
        if (((s - 8'h10) >> 1) >= NUM_PINS) return -1;
        return int'((s - 8'h10) >> 1);
    endfunction

    function automatic string tag_of(input logic [ADDR_W-1:0] a, input logic [3:0] sz);
        if (a[7:0] == 8'h00) return "R3";
        if (a[7:0] != 8'h10) return "R2";
        if (sz != 4'd4) return "R5";
        if (m_sel == 8'h00 || m_sel == 8'h02) return "R6";
        if (m_sel == 8'h01) return "R7";
        if (tab_index(m_sel) < 0) return "R11";
        return "R8";
    endfunction

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a, input logic [3:0] sz);
        int ix;
        if (a[7:0] == 8'h00) return {24'b0, m_sel};
        if (a[7:0] != 8'h10 || sz != 4'd4) return 32'd0;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'b0, m_id, 24'b0};
        if (m_sel == 8'h01) return 32'h11 | (32'(NUM_PINS - 1) << 16);
        ix = tab_index(m_sel);
        if (ix < 0) return 32'd0;
        return m_sel[0] ? m_tab[ix][63:32] : m_tab[ix][31:0];
    endfunction

    // Applies the model's write; returns 1 when a table entry is written.
    function automatic bit model_write(input logic [ADDR_W-1:0] a, input logic [3:0] sz,
                                       input logic [31:0] d);
        int ix;
        if (a[7:0] == 8'h00) begin
            m_sel = d[7:0];
            return 1'b0;
        end
        if (a[7:0] != 8'h10 || sz != 4'd4) return 1'b0;
        if (m_sel == 8'h00) begin
            m_id = d[27:24];
            return 1'b0;
        end
        ix = tab_index(m_sel);
        if (ix < 0) return 1'b0;
        if (m_sel[0]) m_tab[ix][63:32] = d;
        else          m_tab[ix][31:0]  = d;
        return 1'b1;
    endfunction

    task automatic check_table(input string tag);
        for (int i = 0; i < NUM_PINS; i++) check(tag, entries_o[64*i +: 64], m_tab[i]);
    endtask

    // Called at a negedge; ends at the following negedge.
    task automatic do_op(input bit req, input bit we, input logic [ADDR_W-1:0] a,
                         input logic [3:0] sz, input logic [31:0] d);
        logic [31:0] exp_rd;
        bit          exp_stb;
        string       t;
        exp_rd  = model_read(a, sz);
        t       = tag_of(a, sz);
        exp_stb = 1'b0;
        bus_req = req; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
        if (req && we) exp_stb = model_write(a, sz, d);
        @(negedge clk);
        bus_req = 1'b0;
        check("R4 rvalid", 64'(bus_rvalid), 64'(req && !we));
        if (req && !we) check({t, " rdata"}, 64'(bus_rdata), 64'(exp_rd));
        check("R10 strobe", 64'(svc_strobe), 64'(exp_stb));
        if (req && we) check_table("R9 table");
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] sz, input logic [31:0] d);
        do_op(1'b1, 1'b1, a, sz, d);
    endtask
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [3:0] sz);
        do_op(1'b1, 1'b0, a, sz, 32'd0);
    endtask
    task automatic idle();
        do_op(1'b0, 1'b0, '0, 4'd4, 32'd0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        m_sel = 8'h00;
        m_id  = 4'h0;
        for (int i = 0; i < NUM_PINS; i++) m_tab[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rvalid", 64'(bus_rvalid), 64'd0);
        check("R1 strobe", 64'(svc_strobe), 64'd0);
        check_table("R1 entries");
        rd(12'h000, 4'd4);                     // R1/R3 selector 0
        rd(12'h010, 4'd4);                     // R1/R6 id 0
        // R7 version and ignored writes
        wr(12'h000, 4'd1, 32'h0000_0001);      // R3 any size loads selector
        rd(12'h010, 4'd4);
        wr(12'h010, 4'd4, 32'hFFFF_FFFF);      // R7 write ignored
        rd(12'h010, 4'd4);
        // R6 id and arbitration mirror
        wr(12'h000, 4'd4, 32'h0000_0000);
        wr(12'h010, 4'd4, 32'hA500_0000);
        rd(12'h010, 4'd4);
        wr(12'h000, 4'd4, 32'h0000_0002);
        rd(12'h010, 4'd4);
        wr(12'h010, 4'd4, 32'h0F00_0000);      // R7 arbitration write ignored
        rd(12'h010, 4'd4);
        // R8/R9 halves of entry 3, R10 strobe width
        wr(12'h000, 4'd4, 32'h16);
        wr(12'h010, 4'd4, 32'h1234_5678);
        idle();                                 // R10 strobe one cycle only
        wr(12'h000, 4'd4, 32'h17);
        wr(12'h010, 4'd4, 32'hCAFE_F00D);
        rd(12'h010, 4'd4);
        wr(12'h000, 4'd4, 32'h16);
        rd(12'h010, 4'd4);
        // R5 size filter on entry
        wr(12'h010, 4'd2, 32'h0BAD_0BAD);
        rd(12'h010, 4'd1);
        rd(12'h010, 4'd8);
        // R2 alias and unmapped offsets
        wr(12'h000, 4'd4, 32'h10);
        wr(12'h110, 4'd4, 32'h5555_AAAA);
        rd(12'hF10, 4'd4);
        rd(12'h004, 4'd4);
        wr(12'h004, 4'd4, 32'h77);
        rd(12'h100, 4'd4);
        // R11 out of range both sides and last valid entry
        wr(12'h000, 4'd4, 32'h05);
        rd(12'h010, 4'd4);
        wr(12'h010, 4'd4, 32'hDEAD_BEEF);
        wr(12'h000, 4'd4, 32'(8'h10 + 2*NUM_PINS));
        wr(12'h010, 4'd4, 32'hDEAD_BEEF);
        rd(12'h010, 4'd4);
        wr(12'h000, 4'd4, 32'(8'h10 + 2*NUM_PINS - 1));
        wr(12'h010, 4'd4, 32'h0123_4567);
        rd(12'h010, 4'd4);
        // Random phase
        r = $urandom(32'h5EED_1234);
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] a;
            logic [3:0]        sz;
            logic [31:0]       d;
            int                pick;
            pick = $urandom_range(0, 9);
            if (pick < 3)      a = 12'h000;
            else if (pick < 8) a = {4'($urandom_range(0, 15)), 8'h10};
            else               a = ADDR_W'($urandom);
            pick = $urandom_range(0, 9);
            sz = (pick < 8) ? 4'd4 : 4'($urandom_range(0, 8));
            d = $urandom;
            if (a[7:0] == 8'h00 && $urandom_range(0, 3) != 0) d[7:0] = 8'($urandom_range(0, 8'h45));
            pick = $urandom_range(0, 9);
            if (pick < 5)      wr(a, sz, d);
            else if (pick < 9) rd(a, sz);
            else               idle();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule